// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block walks a multi-lane serial PHY from power-down to a calibrated, running state without software stepping it. A single `start` pulse captures a lane mask and a fast-wait selector. The block then drives the PHY's control strobes and level controls in a fixed order, and it watches the done and error returns of the analog calibration engines. Lanes outside the captured mask are never touched. The calibration engines themselves sit outside the block.

The order is as follows. The block halts the embedded lane controller and powers the group clock tree and current reference. It then releases power on the selected lanes, selects AC-coupled receive mode and enables the lanes. Next it requests transmit impedance calibration, waits a settle time and polls the result at a fixed interval. On success it fires the segment-apply strobe. It then stops the phase-rotator flywheel on the selected lanes, starts receive offset calibration and polls each selected lane in ascending order. On success it clears the run bits and bank controls, restarts the flywheel and clears edge tracking. Last, it steps each selected lane's transmit FIFO through its initialisation.

Every wait is produced by one shared down-counter. With the fast-wait selector set, each wait count is shifted down, which shortens runs of the block in simulation. Any failure parks the block in an error state with a code that holds until reset.

Top module: `link_bringup_seq`

## Requirements
- R1: Out of reset, all strobes, lane controls and flags are 0, except `unload_dis`, which is all ones. `start` is accepted only in the idle state, and it captures `lane_mask` and `sim_mode` at that edge.
- R2: After the start edge, `ctl_halt` pulses for one cycle. One cycle after that pulse, `grp_pwr` rises. `lane_pwr` takes the mask one cycle after `grp_pwr` rises, `ac_coupled` rises one cycle after that, and `lane_en` takes the mask one cycle after that.
- R3: `zcal_req` pulses in the cycle after `lane_en` is set. A settle wait of S cycles follows. Each poll cycle samples `zcal_done_i` and `zcal_err_i`, and a failed poll is followed by a gap of G cycles before the next poll. When done and error are both high in the same poll, done wins.
- R4: An error seen in a poll ends the sequence with `err_code` = 1. A run of ZCAL_POLLS polls without done or error ends it with `err_code` = 2.
- R5: A successful impedance poll sets `tx_ok` in the next cycle. `seg_apply` pulses in that same cycle.
- R6: `flywheel_off` takes the mask two cycles after `seg_apply`. `dccal_run` takes the mask one cycle later, and a settle wait follows. Each selected lane is then polled in ascending order, and only its own bit of `dccal_done_i` is looked at. Each lane outside the mask costs one cycle.
- R7: A selected lane that fails DC_POLLS polls ends the sequence with `err_code` = 3 and its index on `err_lane`.
- R8: When the last lane has succeeded, `bank_clr` pulses. The next cycle clears `dccal_run` and sets `rx_ok`. One cycle later `flywheel_off` clears, and `edge_clr` pulses in that same cycle.
- R9: Each selected lane then spends three cycles on its FIFO: a cycle with `unload_dis` still set, then a cycle with its `unload_dis` bit low and its `fifo_init` bit high, then a cycle with `unload_dis` low, after which `unload_dis` is set again.
- R10: In the error state `err` is high and `busy` is low. `err_code` and `err_lane` hold, and `start` is ignored until reset.
- R11: With `sim_mode` captured high, every wait count is shifted right by SIM_SHIFT. A result of 0 becomes 1.
- R12: `busy` is high from the halt cycle until the end of the sequence. After the last FIFO, `done` rises and holds, and further `start` pulses are ignored.
- R13: No per-lane output ever changes for a lane outside the captured mask, and changes to `lane_mask` after the start edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up sequence (from idle) |
| sim_mode | input | 1 | Shortened waits, captured at start |
| lane_mask | input | NUM_LANES (24) | Lanes to bring up, captured at start |
| zcal_done_i | input | 1 | Impedance calibration finished |
| zcal_err_i | input | 1 | Impedance calibration failed |
| dccal_done_i | input | NUM_LANES | Per-lane receive offset calibration finished |
| ctl_halt | output | 1 | One-cycle halt command to the lane controller |
| grp_pwr | output | 1 | Group clock tree and reference powered |
| lane_pwr | output | NUM_LANES | Per-lane power released |
| ac_coupled | output | 1 | AC-coupled receive mode |
| lane_en | output | NUM_LANES | Per-lane enable |
| zcal_req | output | 1 | One-cycle impedance calibration request |
| seg_apply | output | 1 | One-cycle driver segment apply strobe |
| flywheel_off | output | NUM_LANES | Phase-rotator flywheel stopped |
| dccal_run | output | NUM_LANES | Receive offset calibration running |
| bank_clr | output | 1 | One-cycle bank-control clear |
| edge_clr | output | 1 | One-cycle edge-tracking control clear |
| unload_dis | output | NUM_LANES | Transmit FIFO unload clock disabled |
| fifo_init | output | NUM_LANES | One-cycle transmit FIFO init per lane |
| tx_ok | output | 1 | Transmit calibration phase complete |
| rx_ok | output | 1 | Receive calibration phase complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| err | output | 1 | Sequence stopped on a failure |
| err_code | output | 2 | 0 none, 1 impedance error, 2 impedance timeout, 3 lane timeout |
| err_lane | output | $clog2(NUM_LANES) (5) | Lane that timed out |

## Verification
The impedance poll is the place where two results can land in the same cycle. The bench raises `zcal_done_i` and `zcal_err_i` together on the first poll and expects the sequence to continue as a success, with `tx_ok` set and no error code. A second overlap sits in the lane polling. While one lane is polled, the bench holds every other lane's done bit high, so any look at the wrong bit shows up as an early advance. The bench's cycle model, compared on every clock, judges both cases: it schedules the poll, apply and lane steps one cycle at a time.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_HALT, S_GRP, S_LPWR, S_ACC, S_LEN,
    S_ZREQ, S_ZWAIT, S_ZPOLL, S_ZGAP, S_ZAPPLY,
    S_FLYOFF, S_DCRUN, S_DWAIT, S_DPOLL, S_DGAP, S_DFIN,
    S_FLYON, S_EDGE, S_FIFO_A, S_FIFO_B, S_FIFO_C,
    S_DONE, S_ERR
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_ZFAIL = 2'd1,
    ERR_ZTMO = 2'd2,
    ERR_DTMO = 2'd3
  } err_code_e;
endpackage

// File: rtl/lbs_delay.sv
`timescale 1ns/1ps
// Shared wait counter: a load of N makes expired rise in the Nth following cycle.
module lbs_delay #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CNT_W'(1));

  // R11: scaled waits are clamped, so a zero length is never loaded
  p_load_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/lbs_poll.sv
`timescale 1ns/1ps
// Counts failed polls; last flags the final allowed poll.
module lbs_poll #(
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : (cnt_q + PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == PW'(MAX_POLLS - 1));

  // R3: a retry is never scheduled after the final allowed poll
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && last));
endmodule

// File: rtl/link_bringup_seq.sv
`timescale 1ns/1ps
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int NUM_LANES   = 24,
  parameter int CNT_W       = 32,
  parameter int ZCAL_SETTLE = 5000000,
  parameter int ZCAL_GAP    = 2499,
  parameter int ZCAL_POLLS  = 200,
  parameter int DC_SETTLE   = 250000,
  parameter int DC_GAP      = 249999,
  parameter int DC_POLLS    = 200,
  parameter int SIM_SHIFT   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         sim_mode,
  input  logic [NUM_LANES-1:0]         lane_mask,
  input  logic                         zcal_done_i,
  input  logic                         zcal_err_i,
  input  logic [NUM_LANES-1:0]         dccal_done_i,
  output logic                         ctl_halt,
  output logic                         grp_pwr,
  output logic [NUM_LANES-1:0]         lane_pwr,
  output logic                         ac_coupled,
  output logic [NUM_LANES-1:0]         lane_en,
  output logic                         zcal_req,
  output logic                         seg_apply,
  output logic [NUM_LANES-1:0]         flywheel_off,
  output logic [NUM_LANES-1:0]         dccal_run,
  output logic                         bank_clr,
  output logic                         edge_clr,
  output logic [NUM_LANES-1:0]         unload_dis,
  output logic [NUM_LANES-1:0]         fifo_init,
  output logic                         tx_ok,
  output logic                         rx_ok,
  output logic                         busy,
  output logic                         done,
  output logic                         err,
  output logic [1:0]                   err_code,
  output logic [$clog2(NUM_LANES)-1:0] err_lane
);
  localparam int LIDX_W = $clog2(NUM_LANES);
  localparam logic [LIDX_W-1:0]    LAST_LANE = LIDX_W'(NUM_LANES - 1);
  localparam logic [NUM_LANES-1:0] ONE_LANE  = NUM_LANES'(1);
  localparam logic [CNT_W-1:0] ZS_C = CNT_W'(ZCAL_SETTLE);
  localparam logic [CNT_W-1:0] ZG_C = CNT_W'(ZCAL_GAP);
  localparam logic [CNT_W-1:0] DS_C = CNT_W'(DC_SETTLE);
  localparam logic [CNT_W-1:0] DG_C = CNT_W'(DC_GAP);

  seq_state_e            st_q, st_d;
  err_code_e             code_q, code_d;
  logic [LIDX_W-1:0]     idx_q, idx_d, elane_q, elane_d;
  logic [NUM_LANES-1:0]  mask_q, mask_d, lpwr_q, lpwr_d, len_q, len_d;
  logic [NUM_LANES-1:0]  fly_q, fly_d, run_q, run_d, unl_q, unl_d;
  logic                  sim_q, sim_d, grp_q, grp_d, ac_q, ac_d;
  logic                  tx_q, tx_d, rx_q, rx_d;
  logic                  tmr_load, tmr_exp, zp_clr, zp_inc, zp_last, dp_clr, dp_inc, dp_last;
  logic [CNT_W-1:0]      tmr_val;
  logic                  lane_sel, lane_last;

  function automatic logic [CNT_W-1:0] scale(input logic [CNT_W-1:0] v, input logic s);
    logic [CNT_W-1:0] r;
    r = s ? (v >> SIM_SHIFT) : v;
    if (r == '0) r = CNT_W'(1);
    return r;
  endfunction

  lbs_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  lbs_poll #(.MAX_POLLS(ZCAL_POLLS)) u_zpoll (
    .clk(clk), .rst_n(rst_n), .clr(zp_clr), .inc(zp_inc), .last(zp_last));

  lbs_poll #(.MAX_POLLS(DC_POLLS)) u_dpoll (
    .clk(clk), .rst_n(rst_n), .clr(dp_clr), .inc(dp_inc), .last(dp_last));

  assign lane_sel  = mask_q[idx_q];
  assign lane_last = (idx_q == LAST_LANE);

  always_comb begin
    st_d = st_q;   code_d = code_q; idx_d = idx_q; elane_d = elane_q;
    mask_d = mask_q; sim_d = sim_q; grp_d = grp_q; ac_d = ac_q;
    lpwr_d = lpwr_q; len_d = len_q; fly_d = fly_q; run_d = run_q; unl_d = unl_q;
    tx_d = tx_q; rx_d = rx_q;
    tmr_load = 1'b0; tmr_val = '0;
    zp_clr = 1'b0; zp_inc = 1'b0; dp_clr = 1'b0; dp_inc = 1'b0;
    case (st_q)
      S_IDLE:   if (start) begin
                  st_d = S_HALT; mask_d = lane_mask; sim_d = sim_mode;
                end
      S_HALT:   st_d = S_GRP;
      S_GRP:    begin grp_d = 1'b1;    st_d = S_LPWR; end
      S_LPWR:   begin lpwr_d = mask_q; st_d = S_ACC;  end
      S_ACC:    begin ac_d = 1'b1;     st_d = S_LEN;  end
      S_LEN:    begin len_d = mask_q;  st_d = S_ZREQ; end
      S_ZREQ:   begin
                  tmr_load = 1'b1; tmr_val = scale(ZS_C, sim_q); zp_clr = 1'b1;
                  st_d = S_ZWAIT;
                end
      S_ZWAIT, S_ZGAP: if (tmr_exp) st_d = S_ZPOLL;
      S_ZPOLL:  if (zcal_done_i) begin
                  tx_d = 1'b1; st_d = S_ZAPPLY;
                end else if (zcal_err_i) begin
                  code_d = ERR_ZFAIL; st_d = S_ERR;
                end else if (zp_last) begin
                  code_d = ERR_ZTMO; st_d = S_ERR;
                end else begin
                  zp_inc = 1'b1; tmr_load = 1'b1; tmr_val = scale(ZG_C, sim_q);
                  st_d = S_ZGAP;
                end
      S_ZAPPLY: st_d = S_FLYOFF;
      S_FLYOFF: begin fly_d = mask_q; st_d = S_DCRUN; end
      S_DCRUN:  begin
                  run_d = mask_q; idx_d = '0; dp_clr = 1'b1;
                  tmr_load = 1'b1; tmr_val = scale(DS_C, sim_q);
                  st_d = S_DWAIT;
                end
      S_DWAIT, S_DGAP: if (tmr_exp) st_d = S_DPOLL;
      S_DPOLL:  if (!lane_sel || dccal_done_i[idx_q]) begin
                  dp_clr = 1'b1;
                  if (lane_last) st_d = S_DFIN;
                  else           idx_d = idx_q + LIDX_W'(1);
                end else if (dp_last) begin
                  code_d = ERR_DTMO; elane_d = idx_q; st_d = S_ERR;
                end else begin
                  dp_inc = 1'b1; tmr_load = 1'b1; tmr_val = scale(DG_C, sim_q);
                  st_d = S_DGAP;
                end
      S_DFIN:   begin run_d = '0; rx_d = 1'b1; st_d = S_FLYON; end
      S_FLYON:  begin fly_d = '0; st_d = S_EDGE; end
      S_EDGE:   begin idx_d = '0; st_d = S_FIFO_A; end
      S_FIFO_A: if (lane_sel) begin
                  unl_d[idx_q] = 1'b0; st_d = S_FIFO_B;
                end else if (lane_last) st_d = S_DONE;
                else idx_d = idx_q + LIDX_W'(1);
      S_FIFO_B: st_d = S_FIFO_C;
      S_FIFO_C: begin
                  unl_d[idx_q] = 1'b1;
                  if (lane_last) st_d = S_DONE;
                  else begin idx_d = idx_q + LIDX_W'(1); st_d = S_FIFO_A; end
                end
      S_DONE, S_ERR: st_d = st_q;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  code_q <= ERR_NONE; idx_q <= '0; elane_q <= '0;
      mask_q <= '0;    sim_q <= 1'b0;      grp_q <= 1'b0; ac_q <= 1'b0;
      lpwr_q <= '0;    len_q <= '0;        fly_q <= '0;   run_q <= '0;
      unl_q <= '1;     tx_q <= 1'b0;       rx_q <= 1'b0;
    end else begin
      st_q <= st_d;    code_q <= code_d;   idx_q <= idx_d; elane_q <= elane_d;
      mask_q <= mask_d; sim_q <= sim_d;    grp_q <= grp_d; ac_q <= ac_d;
      lpwr_q <= lpwr_d; len_q <= len_d;    fly_q <= fly_d; run_q <= run_d;
      unl_q <= unl_d;  tx_q <= tx_d;       rx_q <= rx_d;
    end
  end

  assign ctl_halt     = (st_q == S_HALT);
  assign zcal_req     = (st_q == S_ZREQ);
  assign seg_apply    = (st_q == S_ZAPPLY);
  assign bank_clr     = (st_q == S_DFIN);
  assign edge_clr     = (st_q == S_EDGE);
  assign fifo_init    = (st_q == S_FIFO_B) ? (ONE_LANE << idx_q) : '0;
  assign grp_pwr      = grp_q;
  assign lane_pwr     = lpwr_q;
  assign ac_coupled   = ac_q;
  assign lane_en      = len_q;
  assign flywheel_off = fly_q;
  assign dccal_run    = run_q;
  assign unload_dis   = unl_q;
  assign tx_ok        = tx_q;
  assign rx_ok        = rx_q;
  assign done         = (st_q == S_DONE);
  assign err          = (st_q == S_ERR);
  assign busy         = !(st_q inside {S_IDLE, S_DONE, S_ERR});
  assign err_code     = code_q;
  assign err_lane     = elane_q;

  // R2: no lane power is released before the group supply
  p_grp_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_pwr) |-> grp_pwr);
  // R6: offset calibration only runs in AC-coupled mode with the flywheel stopped
  p_ac_before_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|dccal_run) |-> (ac_coupled && ((dccal_run & ~flywheel_off) == '0)));
  // R8: the receive flag never leads the transmit flag
  p_tx_before_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> tx_ok);
  // R9: FIFO init only fires while that lane's unload clock runs
  p_init_unloaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_init & unload_dis) == '0);
  // R10: the error state and its code hold
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(err_code) && $stable(err_lane)));
  // R12: completion implies both calibration phases passed
  p_done_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_ok && rx_ok && !busy));
  // R13: lanes outside the captured mask stay untouched
  p_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_pwr | lane_en | flywheel_off | dccal_run | ~unload_dis | fifo_init) & ~mask_q) == '0);
endmodule

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;
  localparam int NL = 24, ZS = 40, ZG = 3, ZM = 6, DS = 20, DG = 5, DM = 4, SH = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sim_mode = 1'b0;
  logic [NL-1:0] lane_mask = '0, dccal_done_i = '0;
  logic zcal_done_i = 1'b0, zcal_err_i = 1'b0;
  logic ctl_halt, grp_pwr, ac_coupled, zcal_req, seg_apply, bank_clr, edge_clr;
  logic tx_ok, rx_ok, busy, done, err;
  logic [NL-1:0] lane_pwr, lane_en, flywheel_off, dccal_run, unload_dis, fifo_init;
  logic [1:0] err_code;
  logic [4:0] err_lane;

  always #2 clk = ~clk;

  link_bringup_seq #(.NUM_LANES(NL), .CNT_W(16), .ZCAL_SETTLE(ZS), .ZCAL_GAP(ZG),
    .ZCAL_POLLS(ZM), .DC_SETTLE(DS), .DC_GAP(DG), .DC_POLLS(DM), .SIM_SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sim_mode(sim_mode), .lane_mask(lane_mask),
    .zcal_done_i(zcal_done_i), .zcal_err_i(zcal_err_i), .dccal_done_i(dccal_done_i),
    .ctl_halt(ctl_halt), .grp_pwr(grp_pwr), .lane_pwr(lane_pwr), .ac_coupled(ac_coupled),
    .lane_en(lane_en), .zcal_req(zcal_req), .seg_apply(seg_apply),
    .flywheel_off(flywheel_off), .dccal_run(dccal_run), .bank_clr(bank_clr),
    .edge_clr(edge_clr), .unload_dis(unload_dis), .fifo_init(fifo_init), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .busy(busy), .done(done), .err(err), .err_code(err_code),
    .err_lane(err_lane));

  int checks = 0, fails = 0;
  bit reported = 1'b0;
  int dhit [NL];

  // expected port values, advanced one cycle at a time by the model
  logic e_halt, e_grp, e_ac, e_zreq, e_seg, e_bank, e_edge, e_tx, e_rx, e_busy, e_done, e_err;
  logic [NL-1:0] e_lpwr, e_len, e_fly, e_run, e_unl, e_init;
  logic [1:0] e_code;
  logic [4:0] e_elane;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2", "ctl_halt", 32'(ctl_halt), 32'(e_halt));
    chk("R2", "grp_pwr", 32'(grp_pwr), 32'(e_grp));
    chk("R2", "lane_pwr", 32'(lane_pwr), 32'(e_lpwr));
    chk("R2", "ac_coupled", 32'(ac_coupled), 32'(e_ac));
    chk("R2", "lane_en", 32'(lane_en), 32'(e_len));
    chk("R3", "zcal_req", 32'(zcal_req), 32'(e_zreq));
    chk("R5", "seg_apply", 32'(seg_apply), 32'(e_seg));
    chk("R5", "tx_ok", 32'(tx_ok), 32'(e_tx));
    chk("R6", "flywheel_off", 32'(flywheel_off), 32'(e_fly));
    chk("R6", "dccal_run", 32'(dccal_run), 32'(e_run));
    chk("R8", "bank_clr", 32'(bank_clr), 32'(e_bank));
    chk("R8", "edge_clr", 32'(edge_clr), 32'(e_edge));
    chk("R8", "rx_ok", 32'(rx_ok), 32'(e_rx));
    chk("R9", "unload_dis", 32'(unload_dis), 32'(e_unl));
    chk("R9", "fifo_init", 32'(fifo_init), 32'(e_init));
    chk("R12", "busy", 32'(busy), 32'(e_busy));
    chk("R12", "done", 32'(done), 32'(e_done));
    chk("R10", "err", 32'(err), 32'(e_err));
    chk("R4", "err_code", 32'(err_code), 32'(e_code));
    chk("R7", "err_lane", 32'(err_lane), 32'(e_elane));
  endtask

  // compare mid-cycle, then move 1 ns past the next rising edge
  task automatic tick();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  function automatic int eff(input int v, input bit sm);
    int r;
    r = sm ? (v >> SH) : v;
    return (r == 0) ? 1 : r;
  endfunction

  task automatic exp_reset();
    {e_halt, e_grp, e_ac, e_zreq, e_seg, e_bank, e_edge, e_tx, e_rx, e_busy, e_done, e_err} = '0;
    e_lpwr = '0; e_len = '0; e_fly = '0; e_run = '0; e_unl = '1; e_init = '0;
    e_code = '0; e_elane = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; zcal_done_i = 1'b0; zcal_err_i = 1'b0; dccal_done_i = '0;
    exp_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();            // R1 reset state
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    tick();               // R1 idle without start
  endtask

  // R10 / R12: terminal state holds and ignores start
  task automatic hold_end();
    tick(); tick();
    start = 1'b1; tick(); start = 1'b0;
    tick(); tick();
  endtask

  task automatic enter_err(input logic [1:0] code, input int lane);
    e_busy = 1'b0; e_err = 1'b1; e_code = code; e_elane = 5'(lane);
    hold_end();
  endtask

  // ztype: 0 done, 1 error, 2 done and error together, 3 never answers
  task automatic run_seq(input logic [NL-1:0] m, input bit sm, input int zhit, input int ztype);
    int zs, zg, ds, dg;
    zs = eff(ZS, sm); zg = eff(ZG, sm); ds = eff(DS, sm); dg = eff(DG, sm);
    start = 1'b1; lane_mask = m; sim_mode = sm;
    tick();                                  // R1 start sampled in idle
    start = 1'b0; lane_mask = ~m; sim_mode = ~sm;   // R13 later mask changes ignored
    e_busy = 1'b1; e_halt = 1'b1; tick(); e_halt = 1'b0;
    tick();
    e_grp = 1'b1; tick();
    e_lpwr = m; tick();
    e_ac = 1'b1; tick();
    e_len = m; e_zreq = 1'b1; tick(); e_zreq = 1'b0;
    repeat (zs) tick();                      // R3 / R11 settle
    for (int p = 0; ; p++) begin
      zcal_done_i = (p == zhit) && (ztype == 0 || ztype == 2);
      zcal_err_i  = (p == zhit) && (ztype == 1 || ztype == 2);
      tick();
      zcal_done_i = 1'b0; zcal_err_i = 1'b0;
      if (p == zhit && (ztype == 0 || ztype == 2)) break;   // R3 done wins
      if (p == zhit && ztype == 1) begin enter_err(2'd1, 0); return; end  // R4
      if (p == ZM - 1) begin enter_err(2'd2, 0); return; end             // R4 timeout
      repeat (zg) tick();
    end
    e_tx = 1'b1; e_seg = 1'b1; tick(); e_seg = 1'b0;   // R5
    tick();
    e_fly = m; tick();
    e_run = m; repeat (ds) tick();           // R6 settle
    for (int l = 0; l < NL; l++) begin
      if (!m[l]) begin tick(); continue; end
      for (int p = 0; ; p++) begin
        dccal_done_i = ~(NL'(1) << l);       // R6 other lanes' bits must not matter
        if (dhit[l] >= 0 && p >= dhit[l]) dccal_done_i[l] = 1'b1;
        tick();
        dccal_done_i = '0;
        if (dhit[l] >= 0 && p >= dhit[l]) break;
        if (p == DM - 1) begin enter_err(2'd3, l); return; end   // R7
        repeat (dg) tick();
      end
    end
    e_bank = 1'b1; tick(); e_bank = 1'b0;    // R8
    e_run = '0; e_rx = 1'b1; tick();
    e_fly = '0; e_edge = 1'b1; tick(); e_edge = 1'b0;
    for (int l = 0; l < NL; l++) begin       // R9
      if (!m[l]) begin tick(); continue; end
      tick();
      e_unl[l] = 1'b0; e_init[l] = 1'b1; tick();
      e_init[l] = 1'b0; tick();
      e_unl[l] = 1'b1;
    end
    e_busy = 1'b0; e_done = 1'b1;            // R12
    hold_end();
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired t=%0t", $time);
    report();
  end

  initial begin
    for (int l = 0; l < NL; l++) dhit[l] = 0;
    // normal waits, sparse mask, impedance done on third poll, lane 2 on its last poll
    do_reset();
    dhit[2] = DM - 1; dhit[5] = 1;
    run_seq(24'h800025, 1'b0, 2, 0);
    // R11 fast waits with clamping, all lanes, done and error in the same poll
    do_reset();
    for (int l = 0; l < NL; l++) dhit[l] = 0;
    dhit[10] = 1;
    run_seq(24'hFFFFFF, 1'b1, 0, 2);
    // R4 impedance error on second poll
    do_reset();
    run_seq(24'h00000F, 1'b0, 1, 1);
    // R4 impedance timeout, fast waits
    do_reset();
    run_seq(24'h000001, 1'b1, -1, 3);
    // R7 lane 4 never finishes after lane 1 succeeds late
    do_reset();
    for (int l = 0; l < NL; l++) dhit[l] = 0;
    dhit[1] = 2; dhit[4] = -1;
    run_seq(24'h000012, 1'b0, 0, 0);
    // R13 empty mask: no lane output may move
    do_reset();
    for (int l = 0; l < NL; l++) dhit[l] = 0;
    run_seq(24'h000000, 1'b0, 0, 0);
    report();
  end
endmodule